// File: doc/BRIEF.md
# Receive I/Q Rail Mapper

This block sits at the head of a receive correction chain and conditions each signed I/Q sample pair from the converter before any other correction sees it. A single control word selects the rail operations. The I and Q rails can be exchanged, and either rail can be negated with saturation. Real mode forces the Q rail to zero. A global bypass hands the raw samples through untouched. The word also carries flags for later stages. One of them enables a quarter-rate downconverter further down the chain, and another tells every later stage to stand aside.

The control word is loaded from a settings bus made of a strobe, an address and a 32-bit data word. The low eight data bits are kept when the address matches the block's parameterised address. Samples enter with a valid flag and leave one clock later from registers. Real-mode handling can be left out at build time with a parameter. When it is left out, the real-mode bit and the downconvert flag are ignored.

Top module: `iq_map_stage`

## Requirements
- R1: After reset the outputs `out_i` and `out_q` are zero, `out_valid` is low, and both `dnconv_en` and `bypass_all` are low. The control word is zero, which means no swap, no negation, complex mode and no bypass.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high.
- R3: A cycle with `cfg_stb` high and `cfg_addr` equal to `MAP_ADDR` loads `cfg_data[7:0]` into the control word. The bits are: bit 0 swap, bit 1 real mode, bit 2 negate Q, bit 3 negate I, bit 4 downconvert enable, bit 7 bypass. A sample presented in the cycle after the write uses the new word. A strobe with any other address changes nothing.
- R4: When bit 0 is set, the processed I value appears on `out_q` and the processed Q value appears on `out_i`.
- R5: Bit 3 negates the I input and bit 2 negates the Q input. Negation is applied to the raw rails before the swap.
- R6: Negating the most negative code (-32768 for 16 bits) gives the most positive code (32767).
- R7: With real-mode DSP built in (`HAS_REAL_DSP`=1), bit 1 makes the Q input count as zero. The rail that carries Q after the swap then reads zero, whatever the Q input is.
- R8: When bit 7 is set, `out_i` and `out_q` equal the raw `in_i` and `in_q`, whatever the other bits are.
- R9: `dnconv_en` follows bit 4 of the control word and `bypass_all` follows bit 7.
- R10: In a cycle with `in_valid` low, `out_i` and `out_q` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_stb | input | 1 | Settings write strobe |
| cfg_addr | input | ADDR_W (8) | Settings write address |
| cfg_data | input | 32 | Settings write data |
| in_valid | input | 1 | Input sample valid |
| in_i | input | SAMPLE_W (16) | Signed I input |
| in_q | input | SAMPLE_W (16) | Signed Q input |
| out_valid | output | 1 | Output sample valid |
| out_i | output | SAMPLE_W (16) | Signed I output |
| out_q | output | SAMPLE_W (16) | Signed Q output |
| dnconv_en | output | 1 | Downconvert enable flag for later stages |
| bypass_all | output | 1 | Bypass flag for later stages |

## Verification
Random sample pairs run under random control words. This shows whether each bit acts on the intended rail and whether the effects combine in the right order. A directed pair with unequal magnitudes and opposite signs is run under swap plus I negation. It separates negate-then-swap from swap-then-negate. Most-negative inputs under negation expose wraparound, and nonzero Q under real mode separates zeroing from passing. Writes to a foreign address, followed by sampling, show that the control word was left alone.

// File: rtl/iq_map_pkg.sv
package iq_map_pkg;
   localparam int CTRL_W = 8;

   // Field layout of the control word (bit positions are software-visible)
   typedef struct packed {
      logic       bypass;   // bit 7
      logic [1:0] spare;    // bits 6:5
      logic       dnconv;   // bit 4
      logic       neg_i;    // bit 3
      logic       neg_q;    // bit 2
      logic       real_md;  // bit 1
      logic       swap;     // bit 0
   } map_ctrl_t;
endpackage

// File: rtl/iq_map_cfg.sv
module iq_map_cfg
   import iq_map_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int MAP_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_stb,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_data,
   output map_ctrl_t         ctrl
);
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(MAP_ADDR);

   if (DATA_W < CTRL_W) begin : g_bad_dw
      $error("DATA_W must hold the control word");
   end

   logic hit;
   assign hit = cfg_stb && (cfg_addr == HIT_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n)   ctrl <= '0;
      else if (hit) ctrl <= map_ctrl_t'(cfg_data[CTRL_W-1:0]);
   end

   assert_cfg_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> ctrl == map_ctrl_t'($past(cfg_data[CTRL_W-1:0])));
   assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(ctrl));
endmodule

// File: rtl/iq_sat_negate.sv
module iq_sat_negate #(
   parameter int W = 16
) (
   input  logic signed [W-1:0] din,
   output logic signed [W-1:0] dout
);
   localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic signed [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

   always_comb begin
      if (din == MOST_NEG) dout = MOST_POS;
      else                 dout = -din;
   end
endmodule

// File: rtl/iq_map_core.sv
module iq_map_core
   import iq_map_pkg::*;
#(
   parameter int W            = 16,
   parameter bit HAS_REAL_DSP = 1'b1
) (
   input  map_ctrl_t          ctrl,
   input  logic signed [W-1:0] raw_i,
   input  logic signed [W-1:0] raw_q,
   output logic signed [W-1:0] map_i,
   output logic signed [W-1:0] map_q
);
   logic signed [W-1:0] q_src;
   logic signed [W-1:0] rail [2];
   logic signed [W-1:0] rail_neg [2];
   logic signed [W-1:0] rail_sel [2];
   logic                rail_inv [2];

   // Real-mode zeroing of the Q rail exists only when the option is built
   if (HAS_REAL_DSP) begin : g_real
      assign q_src = ctrl.real_md ? '0 : raw_q;
   end else begin : g_no_real
      assign q_src = raw_q;
   end

   assign rail[0]     = raw_i;
   assign rail[1]     = q_src;
   assign rail_inv[0] = ctrl.neg_i;
   assign rail_inv[1] = ctrl.neg_q;

   for (genvar r = 0; r < 2; r++) begin : g_rail
      iq_sat_negate #(.W(W)) u_neg (.din(rail[r]), .dout(rail_neg[r]));
      assign rail_sel[r] = rail_inv[r] ? rail_neg[r] : rail[r];
   end

   always_comb begin
      if (ctrl.bypass) begin
         map_i = raw_i;
         map_q = raw_q;
      end else if (ctrl.swap) begin
         map_i = rail_sel[1];
         map_q = rail_sel[0];
      end else begin
         map_i = rail_sel[0];
         map_q = rail_sel[1];
      end
   end
endmodule

// File: rtl/iq_map_stage.sv
module iq_map_stage
   import iq_map_pkg::*;
#(
   parameter int SAMPLE_W     = 16,
   parameter int ADDR_W       = 8,
   parameter int MAP_ADDR     = 0,
   parameter bit HAS_REAL_DSP = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_stb,
   input  logic [ADDR_W-1:0]          cfg_addr,
   input  logic [31:0]                cfg_data,
   input  logic                       in_valid,
   input  logic signed [SAMPLE_W-1:0] in_i,
   input  logic signed [SAMPLE_W-1:0] in_q,
   output logic                       out_valid,
   output logic signed [SAMPLE_W-1:0] out_i,
   output logic signed [SAMPLE_W-1:0] out_q,
   output logic                       dnconv_en,
   output logic                       bypass_all
);
   localparam logic signed [SAMPLE_W-1:0] S_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};
   localparam logic signed [SAMPLE_W-1:0] S_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};

   if (SAMPLE_W < 2) begin : g_bad_w
      $error("SAMPLE_W must be at least 2");
   end
   if (MAP_ADDR < 0 || MAP_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("MAP_ADDR does not fit in ADDR_W");
   end

   map_ctrl_t                 ctrl;
   logic signed [SAMPLE_W-1:0] map_i, map_q;

   iq_map_cfg #(.ADDR_W(ADDR_W), .DATA_W(32), .MAP_ADDR(MAP_ADDR)) u_cfg (
      .clk, .rst_n, .cfg_stb, .cfg_addr, .cfg_data, .ctrl
   );

   iq_map_core #(.W(SAMPLE_W), .HAS_REAL_DSP(HAS_REAL_DSP)) u_core (
      .ctrl, .raw_i(in_i), .raw_q(in_q), .map_i, .map_q
   );

   if (HAS_REAL_DSP) begin : g_dn
      assign dnconv_en = ctrl.dnconv;
   end else begin : g_no_dn
      assign dnconv_en = 1'b0;
   end
   assign bypass_all = ctrl.bypass;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_i <= map_i;
            out_q <= map_q;
         end
      end
   end

   assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_i) && $stable(out_q));
   assert_bypass_raw_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && bypass_all) |=> (out_i == $past(in_i)) && (out_q == $past(in_q)));
   assert_sat_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !ctrl.bypass && !ctrl.swap && ctrl.neg_i && in_i == S_MIN)
      |=> out_i == S_MAX);
   if (HAS_REAL_DSP) begin : g_real_chk
      assert_real_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !ctrl.bypass && !ctrl.swap && ctrl.real_md) |=> out_q == '0);
   end
endmodule

// File: tb/iq_map_stage_test.sv
module iq_map_stage_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_stb = 1'b0;
   logic [7:0] cfg_addr = '0;
   logic [31:0] cfg_data = '0;
   logic in_valid = 1'b0;
   logic signed [15:0] in_i = '0, in_q = '0;
   logic out_valid, dnconv_en, bypass_all;
   logic signed [15:0] out_i, out_q;

   int total = 0, bad = 0;
   logic [7:0] ctrl_m = '0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   iq_map_stage #(.SAMPLE_W(16), .ADDR_W(8), .MAP_ADDR(3), .HAS_REAL_DSP(1'b1)) uut (
      .clk, .rst_n, .cfg_stb, .cfg_addr, .cfg_data, .in_valid, .in_i, .in_q,
      .out_valid, .out_i, .out_q, .dnconv_en, .bypass_all
   );

   function automatic int sneg(input int v);
      return (v == -32768) ? 32767 : -v;
   endfunction

   function automatic void model(input int i, input int q, input logic [7:0] c,
                                 output int ei, output int eq);
      int a, b;
      a = i; b = c[1] ? 0 : q;
      if (c[3]) a = sneg(a);
      if (c[2]) b = sneg(b);
      if (c[0]) begin ei = b; eq = a; end else begin ei = a; eq = b; end
      if (c[7]) begin ei = i; eq = q; end
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cfg_stb = 1'b1; cfg_addr = a; cfg_data = d;
      @(negedge clk);
      cfg_stb = 1'b0;
      if (a == 8'd3) ctrl_m = d[7:0];
   endtask

   task automatic send(input string tag, input int i, input int q);
      int ei, eq;
      model(i, q, ctrl_m, ei, eq);
      in_i = 16'(i); in_q = 16'(q); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag, " valid R2"}, int'(out_valid), 1);
      chk({tag, " out_i"}, int'(out_i), ei);
      chk({tag, " out_q"}, int'(out_q), eq);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 out_valid", int'(out_valid), 0);
      chk("R1 out_i", int'(out_i), 0);
      chk("R1 out_q", int'(out_q), 0);
      chk("R1 dnconv_en", int'(dnconv_en), 0);
      chk("R1 bypass_all", int'(bypass_all), 0);
      rst_n = 1'b1;
      @(negedge clk);
      send("R1 default passthrough", 1234, -567);

      // R10 hold while idle, R2 valid drops
      @(negedge clk);
      chk("R2 valid low", int'(out_valid), 0);
      chk("R10 out_i held", int'(out_i), 1234);
      chk("R10 out_q held", int'(out_q), -567);

      // R4 swap
      wr(8'd3, 32'h01);
      send("R4 swap", 100, -200);
      // R5 order: negate I then swap -> out_q = -I
      wr(8'd3, 32'h09);
      send("R5 negI+swap", 100, -5);
      chk("R5 order out_q", int'(out_q), -100);
      wr(8'd3, 32'h04);
      send("R5 negQ", 7, 300);
      // R6 saturation
      wr(8'd3, 32'h0C);
      send("R6 both min", -32768, -32768);
      chk("R6 sat I", int'(out_i), 32767);
      // R7 real mode
      wr(8'd3, 32'h06);
      send("R7 real", 555, -12345);
      chk("R7 q zero", int'(out_q), 0);
      wr(8'd3, 32'h03);
      send("R7 real+swap", -42, 999);
      chk("R7 i zero after swap", int'(out_i), 0);
      // R8 bypass with all bits, R9 flags
      wr(8'd3, 32'hFF);
      chk("R9 dnconv_en", int'(dnconv_en), 1);
      chk("R9 bypass_all", int'(bypass_all), 1);
      send("R8 bypass", -32768, 321);
      wr(8'd3, 32'h10);
      chk("R9 dnconv only", int'(dnconv_en), 1);
      chk("R9 bypass off", int'(bypass_all), 0);
      // R3 foreign address ignored
      wr(8'd4, 32'h81);
      chk("R3 foreign bypass", int'(bypass_all), 0);
      chk("R3 foreign dnconv", int'(dnconv_en), 1);
      send("R3 foreign sample", 11, 22);
      // R3 write then immediate sample uses new word
      wr(8'd3, 32'h08);
      send("R3 next sample", 77, 88);

      // random mix
      for (int k = 0; k < 300; k++) begin
         if ((k % 5) == 0) wr(($urandom % 4 == 0) ? 8'($urandom) : 8'd3, $urandom);
         send("R4 R5 R7 R8 random", int'($signed(16'($urandom))), int'($signed(16'($urandom))));
         if ($urandom % 3 == 0) begin
            int hi, hq;
            hi = int'(out_i); hq = int'(out_q);
            @(negedge clk);
            chk("R10 random hold i", int'(out_i), hi);
            chk("R10 random hold q", int'(out_q), hq);
            chk("R9 random bypass flag", int'(bypass_all), int'(ctrl_m[7]));
         end
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule